// File: doc/BRIEF.md
# Power-On Boot and Reset Sequencer

This block runs the start-up sequence of a supervisory controller after its power-on reset. Reset clears every working register to zero. The sequencer then walks a fixed address window (0Fh up to 7Dh) and reads each entry from a nonvolatile store through a request/done read port. It writes each returned byte into the same address of the default-page register file.

While the copy runs, the block shuts out the host. Host writes are dropped and host reads return zero. It also asserts a fault mask, keeps the general-purpose and enable outputs undriven (output enable low), and holds its reset output low. Once the last address is written, a sticky boot-done flag rises and the host gets access. The reset output is then released after a programmable timeout. That timeout counts only while every monitored channel reports in range. Its length comes from a two-bit selector that is part of the copied configuration.

Top module: `boot_rst_seq`

## Requirements
- R1: While `rst_n` is low, `boot_done` and `rst_out_n` are 0, `fault_mask` is 1, `io_drive_en` is 0 and `host_rd_data` is 0.
- R2: The copy issues exactly 111 reads, one `nv_rd_req` pulse per address, in ascending order from 0Fh to 7Dh. The next request comes only after `nv_rd_done` has been seen for the previous one.
- R3: After boot, each address from 0Fh to 7Dh holds the byte returned for it. Addresses 00h–0Eh and 7Eh–7Fh still read 00h.
- R4: `boot_done` rises in the cycle right after the clock edge that samples `nv_rd_done` for address 7Dh. It stays high until reset, and it stays low before that edge.
- R5: While `boot_done` is 0, host writes have no effect and `host_rd_data` reads 0.
- R6: Once `boot_done` is 1, a host write changes the addressed register, and `host_rd_data` returns it combinationally.
- R7: `fault_mask` is 1 and `io_drive_en` is 0 while `boot_done` is 0. The two values are reversed once `boot_done` is 1.
- R8: `rst_out_n` is 0 for as long as `boot_done` is 0.
- R9: After boot, `rst_out_n` goes to 1 after `all_in_range` has been sampled high on L consecutive rising edges. L = 4 << S, where S is bits [1:0] of register 10h, so S = 0, 1, 2, 3 gives L = 4, 8, 16, 32.
- R10: If `all_in_range` is sampled low, the count restarts from zero. If `rst_out_n` was already 1, it returns to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| nv_rd_req | output | 1 | One-cycle read request to the nonvolatile store |
| nv_rd_addr | output | 7 | Address of the requested byte |
| nv_rd_done | input | 1 | Read data valid, one cycle |
| nv_rd_data | input | 8 | Data returned by the store |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 7 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rd_data | output | 8 | Host read data, zero while locked |
| all_in_range | input | 1 | All monitored channels within thresholds |
| boot_done | output | 1 | Boot copy finished |
| fault_mask | output | 1 | Suppresses fault generation |
| io_drive_en | output | 1 | Output enable for GPIO and enable pins |
| rst_out_n | output | 1 | Active-low system reset output |

## Verification
The assertions check the following on every cycle:
- The reset output stays low while boot is incomplete.
- A sampled out-of-range condition pulls the reset output low at the next cycle.
- Read requests stay inside the copy window.
- The done flag is sticky and only rises after the write to the last address.
- Copy writes happen only while the host is locked out.

Only the bench can show the following:
- The exact address order and request count.
- That the copied bytes land at the correct addresses and the locations outside the window stay clear.
- That host writes made during boot are lost.
- That each selector value gives exactly the cycle count it should, both at first release and after a mid-count restart.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [1:0] {
      BS_CLEAR = 2'd0,
      BS_ISSUE = 2'd1,
      BS_WAIT  = 2'd2,
      BS_DONE  = 2'd3
   } boot_state_e;

   // Timeout length for a selector value: base cycles scaled by powers of two.
   function automatic int unsigned to_cycles(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned sel);
      return base << (step * sel);
   endfunction

endpackage

// File: rtl/boot_copy_fsm.sv
module boot_copy_fsm
   import boot_seq_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int FIRST  = 15,
   parameter int LAST   = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              nv_rd_req,
   output logic [ADDR_W-1:0] nv_rd_addr,
   input  logic              nv_rd_done,
   input  logic [DATA_W-1:0] nv_rd_data,
   output logic              cp_we,
   output logic [ADDR_W-1:0] cp_addr,
   output logic [DATA_W-1:0] cp_wdata,
   output logic              boot_done
);

   localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST);
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(LAST);

   boot_state_e       state_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BS_CLEAR;
         addr_q  <= '0;
      end else begin
         unique case (state_q)
            BS_CLEAR: begin
               addr_q  <= FIRST_A;
               state_q <= BS_ISSUE;
            end
            BS_ISSUE: state_q <= BS_WAIT;
            BS_WAIT: begin
               if (nv_rd_done) begin
                  if (addr_q == LAST_A) begin
                     state_q <= BS_DONE;
                  end else begin
                     addr_q  <= addr_q + ADDR_W'(1);
                     state_q <= BS_ISSUE;
                  end
               end
            end
            default: state_q <= BS_DONE;
         endcase
      end
   end

   assign nv_rd_req  = (state_q == BS_ISSUE);
   assign nv_rd_addr = addr_q;
   assign cp_we      = (state_q == BS_WAIT) && nv_rd_done;
   assign cp_addr    = addr_q;
   assign cp_wdata   = nv_rd_data;
   assign boot_done  = (state_q == BS_DONE);

   assert_req_in_window_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      nv_rd_req |-> (nv_rd_addr >= FIRST_A) && (nv_rd_addr <= LAST_A));

   assert_done_sticky_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> boot_done);

   assert_done_after_last_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boot_done) |-> ($past(cp_we) && ($past(cp_addr) == LAST_A)));

endmodule

// File: rtl/boot_shadow_regs.sv
module boot_shadow_regs #(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int CFG_ADDR = 16,
   parameter int SEL_LSB  = 0,
   parameter int SEL_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              cp_we,
   input  logic [ADDR_W-1:0] cp_addr,
   input  logic [DATA_W-1:0] cp_wdata,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rd_data,
   output logic [SEL_W-1:0]  cfg_sel
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic              host_we;

   assign host_we = host_wr && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (cp_we) begin
         mem_q[cp_addr] <= cp_wdata;
      end else if (host_we) begin
         mem_q[host_addr] <= host_wdata;
      end
   end

   assign host_rd_data = lock ? '0 : mem_q[host_addr];
   assign cfg_sel      = mem_q[CFG_ADDR][SEL_LSB +: SEL_W];

   assert_copy_only_locked_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      cp_we |-> lock);

endmodule

// File: rtl/boot_rst_timer.sv
module boot_rst_timer
   import boot_seq_pkg::*;
#(
   parameter int SEL_W   = 2,
   parameter int TO_BASE = 4,
   parameter int TO_STEP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             in_range,
   input  logic [SEL_W-1:0] sel,
   output logic             rst_out_n
);

   localparam int NSEL   = 1 << SEL_W;
   localparam int MAX_TO = int'(to_cycles(TO_BASE, TO_STEP, NSEL - 1));
   localparam int CNT_W  = $clog2(MAX_TO + 1);

   logic [CNT_W-1:0] tbl [NSEL];
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt_q;
   logic             rel_q;

   for (genvar g = 0; g < NSEL; g++) begin : g_tbl
      assign tbl[g] = CNT_W'(to_cycles(TO_BASE, TO_STEP, g));
   end

   assign limit = tbl[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rel_q <= 1'b0;
      end else if (!enable || !in_range) begin
         cnt_q <= '0;
         rel_q <= 1'b0;
      end else if (!rel_q) begin
         if (cnt_q >= limit - CNT_W'(1)) rel_q <= 1'b1;
         else                            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign rst_out_n = rel_q;

   assert_rst_low_in_boot_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !rst_out_n);

   assert_drop_reasserts_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_range |=> !rst_out_n);

   assert_release_needs_range_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n) |-> ($past(in_range) && $past(enable)));

endmodule

// File: rtl/boot_rst_seq.sv
module boot_rst_seq #(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int FIRST    = 15,
   parameter int LAST     = 125,
   parameter int CFG_ADDR = 16,
   parameter int SEL_LSB  = 0,
   parameter int SEL_W    = 2,
   parameter int TO_BASE  = 4,
   parameter int TO_STEP  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              nv_rd_req,
   output logic [ADDR_W-1:0] nv_rd_addr,
   input  logic              nv_rd_done,
   input  logic [DATA_W-1:0] nv_rd_data,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rd_data,
   input  logic              all_in_range,
   output logic              boot_done,
   output logic              fault_mask,
   output logic              io_drive_en,
   output logic              rst_out_n
);

   if (FIRST > LAST || LAST >= (1 << ADDR_W)) begin : g_bad_window
      $error("copy window does not fit the address space");
   end
   if (CFG_ADDR < FIRST || CFG_ADDR > LAST) begin : g_bad_cfg
      $error("timeout selector must lie inside the copied window");
   end
   if (SEL_LSB + SEL_W > DATA_W || TO_BASE < 1) begin : g_bad_sel
      $error("timeout selector field or base out of range");
   end

   logic              cp_we;
   logic [ADDR_W-1:0] cp_addr;
   logic [DATA_W-1:0] cp_wdata;
   logic [SEL_W-1:0]  cfg_sel;

   boot_copy_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIRST(FIRST), .LAST(LAST)
   ) u_copy (
      .clk(clk), .rst_n(rst_n),
      .nv_rd_req(nv_rd_req), .nv_rd_addr(nv_rd_addr),
      .nv_rd_done(nv_rd_done), .nv_rd_data(nv_rd_data),
      .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
      .boot_done(boot_done)
   );

   boot_shadow_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
      .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .lock(!boot_done),
      .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rd_data(host_rd_data), .cfg_sel(cfg_sel)
   );

   boot_rst_timer #(
      .SEL_W(SEL_W), .TO_BASE(TO_BASE), .TO_STEP(TO_STEP)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .enable(boot_done),
      .in_range(all_in_range), .sel(cfg_sel), .rst_out_n(rst_out_n)
   );

   assign fault_mask  = !boot_done;
   assign io_drive_en = boot_done;

endmodule

// File: tb/tb_boot_rst_seq.sv
`timescale 1ns/100ps
module tb_boot_rst_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nv_rd_req;
   logic [6:0] nv_rd_addr;
   logic       nv_rd_done = 1'b0;
   logic [7:0] nv_rd_data = '0;
   logic       host_wr = 1'b0;
   logic [6:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rd_data;
   logic       all_in_range = 1'b1;
   logic       boot_done, fault_mask, io_drive_en, rst_out_n;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   boot_rst_seq dut (
      .clk(clk), .rst_n(rst_n),
      .nv_rd_req(nv_rd_req), .nv_rd_addr(nv_rd_addr),
      .nv_rd_done(nv_rd_done), .nv_rd_data(nv_rd_data),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rd_data(host_rd_data), .all_in_range(all_in_range),
      .boot_done(boot_done), .fault_mask(fault_mask),
      .io_drive_en(io_drive_en), .rst_out_n(rst_out_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   function automatic logic [7:0] nv_val(input int a, input int seed, input int sel);
      if (a == 16) return {6'(seed), 2'(sel)};
      return 8'(a * 37 + seed * 11);
   endfunction

   task automatic nv_model(input int lat, input int seed, input int sel);
      int exp_a = 15;
      int reqs  = 0;
      @(negedge clk);
      forever begin
         while (!nv_rd_req) begin
            chk(boot_done == 1'b0, "R4 done early", int'(boot_done), 0);
            @(negedge clk);
         end
         chk(int'(nv_rd_addr) == exp_a, "R2 address order", int'(nv_rd_addr), exp_a);
         reqs++;
         repeat (lat) begin
            @(negedge clk);
            chk(nv_rd_req == 1'b0, "R2 request before done", int'(nv_rd_req), 0);
         end
         nv_rd_done = 1'b1;
         nv_rd_data = nv_val(exp_a, seed, sel);
         @(negedge clk);
         nv_rd_done = 1'b0;
         if (exp_a == 125) begin
            chk(boot_done == 1'b1, "R4 done after last", int'(boot_done), 1);
            chk(reqs == 111, "R2 read count", reqs, 111);
            break;
         end
         exp_a++;
      end
   endtask

   task automatic boot_monitor();
      int bad_mask = 0;
      int bad_rst  = 0;
      int bad_host = 0;
      repeat (6) @(negedge clk);
      host_addr  = 7'h05; host_wdata = 8'hAA; host_wr = 1'b1;
      @(negedge clk);
      host_addr  = 7'h7E; host_wdata = 8'h99;
      @(negedge clk);
      host_wr    = 1'b0; host_addr = 7'h10;
      while (!boot_done) begin
         if (fault_mask !== 1'b1 || io_drive_en !== 1'b0) bad_mask++;
         if (rst_out_n !== 1'b0) bad_rst++;
         if (host_rd_data !== 8'h00) bad_host++;
         @(negedge clk);
      end
      chk(bad_mask == 0, "R7 mask/drive during boot", bad_mask, 0);
      chk(bad_rst == 0, "R8 reset low during boot", bad_rst, 0);
      chk(bad_host == 0, "R5 host read locked", bad_host, 0);
   endtask

   task automatic run(input int sel, input int lat, input int seed);
      int n;
      int lim = 4 << sel;
      rst_n = 1'b0; all_in_range = 1'b1; host_wr = 1'b0; nv_rd_done = 1'b0;
      repeat (3) @(negedge clk);
      chk(boot_done == 0 && rst_out_n == 0 && fault_mask == 1 &&
          io_drive_en == 0 && host_rd_data == 0, "R1 reset state",
          {boot_done, rst_out_n, fault_mask, io_drive_en}, 4'b0010);
      rst_n = 1'b1;
      fork
         nv_model(lat, seed, sel);
         boot_monitor();
      join
      chk(fault_mask == 0 && io_drive_en == 1, "R7 after boot",
          {fault_mask, io_drive_en}, 2'b01);
      n = 0;
      do begin @(negedge clk); n++; end while (!rst_out_n);
      chk(n == lim, "R9 timeout length", n, lim);
      for (int a = 0; a < 128; a++) begin
         int e;
         host_addr = 7'(a);
         #0.5;
         e = (a >= 15 && a <= 125) ? int'(nv_val(a, seed, sel)) : 0;
         chk(int'(host_rd_data) == e, (a >= 15 && a <= 125) ? "R3 copied byte" :
             "R3 R5 outside window zero", int'(host_rd_data), e);
      end
      @(negedge clk);
      host_addr = 7'h7E; host_wdata = 8'h3C; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
      #0.5;
      chk(host_rd_data == 8'h3C, "R6 host write after boot", int'(host_rd_data), 8'h3C);
      @(negedge clk);
      all_in_range = 1'b0;
      @(negedge clk);
      chk(rst_out_n == 1'b0, "R10 reassert on drop", int'(rst_out_n), 0);
      all_in_range = 1'b1;
      repeat (lim - 1) @(negedge clk);
      chk(rst_out_n == 1'b0, "R10 not released early", int'(rst_out_n), 0);
      all_in_range = 1'b0;
      @(negedge clk);
      all_in_range = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!rst_out_n);
      chk(n == lim, "R10 restart full count", n, lim);
   endtask

   initial begin
      #(200000 * 5);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      for (int lat = 1; lat <= 2; lat++) begin
         for (int sel = 0; sel < 4; sel++) begin
            run(sel, lat, sel * 5 + lat * 3 + 1);
         end
      end
      summary();
      $finish;
   end

endmodule